// File: doc/BRIEF.md
# SPI Radio Register Access Sequencer

This block is an SPI master that carries out single-register transactions with a radio transceiver. A host asks for one of three operations: a command strobe, a 16-bit register write or a 16-bit register read. The host presents an opcode, a 6-bit register address and the write data, and the block acknowledges the request. The block then requests the shared SPI bus. Once the bus is granted, it drops chip select and shifts the frame out in SPI mode 0, MSB first. When the frame ends it raises chip select, releases the bus and pulses `done`. The status byte and the read data stay on the outputs until the next `done`.

The opcode decides the first byte on the wire. For a strobe or a write, that byte is the address with its two top bits clear. For a read, bit 6 is also set. A strobe sends only this byte. A write adds the data high byte and then the data low byte. A read adds two zero bytes, and the two bytes received during them form the result, high byte first. The byte received during the address byte is the status. Bits 7 and 0 of the status are reserved and are always returned as zero. Taking `enable` low aborts the transaction, including a wait for the bus grant or a wait for a byte to finish. The block then ends the transaction with all-zero results.

States and transitions:
- `ST_IDLE` goes to `ST_WAIT_GRANT` when a request is accepted.
- `ST_WAIT_GRANT` goes to `ST_LEAD` when the grant arrives.
- `ST_LEAD` is a chip-select setup of one SCLK half period. It goes to `ST_SHIFT` on the next half-period tick.
- `ST_SHIFT` shifts the bytes. It goes to `ST_TRAIL` when the last byte completes.
- `ST_TRAIL` is a hold of one half period. It goes to `ST_FINISH` on the next tick.
- `ST_FINISH` lasts one cycle and returns to `ST_IDLE`.
- An abort moves the block from `ST_WAIT_GRANT`, `ST_LEAD`, `ST_SHIFT` or `ST_TRAIL` straight to `ST_FINISH`.

Top module: `radio_reg_seq`

## Requirements
- R1: A request (`req` high) is accepted only while `busy` is low. `ack` is high in the accepting cycle and `busy` is high from the next cycle. While busy, `req` is ignored: `ack` stays low and the frame in progress is unchanged.
- R2: After accepting a request, the block raises `bus_req` and keeps `cs_n` high until `bus_grant` is seen high. `bus_req` stays high while `cs_n` is low and falls when `done` pulses.
- R3: Opcode 2'b00 (strobe), and also the spare code 2'b11, sends one byte equal to {2'b00, addr}. `status` equals the byte received during it AND 8'h7E, and `rdata` is zero.
- R4: Opcode 2'b01 (write) sends three bytes: {2'b00, addr}, then wdata[15:8], then wdata[7:0]. `status` is taken from the first received byte as in R3.
- R5: Opcode 2'b10 (read) sends {2'b01, addr}, then two 8'h00 bytes. `rdata` is {second received byte, third received byte}, and `status` is taken from the first received byte.
- R6: `cs_n` stays low across the whole frame. At least one SCLK half period (CLK_DIV/2 clock cycles) separates the fall of `cs_n` from the first SCLK rise, and the last SCLK fall from the rise of `cs_n`.
- R7: SCLK idles low. Bits go out MSB first, with MOSI set before each rising edge and MISO sampled at it. Within a byte the SCLK period is CLK_DIV clock cycles.
- R8: While `enable` is low, any transaction in progress ends within a frame: `done` pulses, `status` and `rdata` are zero, `cs_n` is high, SCLK is low and `bus_req` is low. This includes a transaction still waiting for the grant.
- R9: `done` is a single-cycle pulse. `status` and `rdata` hold their values after it until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Low aborts any transaction in progress |
| req | input | 1 | Transaction request |
| req_op | input | 2 | 00 strobe, 01 write, 10 read, 11 strobe |
| req_addr | input | 6 | Register or strobe address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Transaction active |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 8 | Masked status byte |
| rdata | output | 16 | Read result |
| bus_req | output | 1 | Request for the shared SPI bus |
| bus_grant | input | 1 | Bus granted |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Slave data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions rely on two assumptions about the inputs. First, `bus_grant` stays high for as long as `bus_req` is held once it has been given. Second, `enable` changes only between clock edges. The bench drives every input at the falling clock edge. It raises the grant only after `bus_req` is up and leaves it high until the transaction completes. The SPI slave model changes MISO right after each SCLK rise, so MISO is stable for a full SCLK period before the master samples it.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 6;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int FRAME_MAX = 3;
    localparam int IDX_W     = $clog2(FRAME_MAX);
    localparam logic [BYTE_W-1:0] STATUS_KEEP = 8'h7E;

    typedef enum logic [1:0] {
        OP_STROBE = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_SPARE  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_GRANT,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/rsq_half_timer.sv
module rsq_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_tick_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick || (HALF == 1));
endmodule

// File: rtl/rsq_shift_engine.sv
module rsq_shift_engine #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic            tick,
    input  logic [BITS-1:0] tx_byte,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic [BITS-1:0] rx_byte,
    output logic            byte_done
);
    localparam int BIT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

    logic            active;
    logic [BITS-1:0] tx_sh;
    logic [BIT_W-1:0] bit_cnt;

    assign mosi = active ? tx_sh[BITS-1] : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            sclk      <= 1'b0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (abort) begin
                active <= 1'b0;
                sclk   <= 1'b0;
            end else if (start) begin
                active  <= 1'b1;
                sclk    <= 1'b0;
                tx_sh   <= tx_byte;
                bit_cnt <= '0;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[BITS-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == LAST_BIT) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        tx_sh   <= {tx_sh[BITS-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    p_byte_ends_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !sclk);
    p_sclk_only_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> active);
endmodule

// File: rtl/radio_reg_seq.sv
module radio_reg_seq
    import rsq_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              req,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              ack,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] status,
    output logic [WORD_W-1:0] rdata,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam logic [IDX_W-1:0] IDX_LONG = IDX_W'(FRAME_MAX - 1);

    seq_state_e state, nxt;

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] rx_q [FRAME_MAX];
    logic              run, tick, byte_done, start;
    logic [BYTE_W-1:0] rx_byte, tx_sel;
    logic [IDX_W-1:0]  last_idx, nidx;
    logic              has_data;

    function automatic logic [BYTE_W-1:0] frame_byte(
        input op_e               op,
        input logic [ADDR_W-1:0] addr,
        input logic [WORD_W-1:0] wd,
        input logic [IDX_W-1:0]  n
    );
        logic [BYTE_W-1:0] b;
        b = '0;
        if (n == '0) begin
            b = {1'b0, (op == OP_READ), addr};
        end else if (op == OP_WRITE) begin
            b = (n == IDX_W'(1)) ? wd[WORD_W-1:BYTE_W] : wd[BYTE_W-1:0];
        end
        return b;
    endfunction

    assign has_data = (op_q == OP_WRITE) || (op_q == OP_READ);
    assign last_idx = has_data ? IDX_LONG : '0;
    assign nidx     = (state == ST_LEAD) ? '0 : IDX_W'(idx + 1'b1);
    assign tx_sel   = frame_byte(op_q, addr_q, wdata_q, nidx);
    assign start    = enable && (((state == ST_LEAD) && tick) ||
                      ((state == ST_SHIFT) && byte_done && (idx != last_idx)));

    rsq_half_timer #(.HALF(HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    rsq_shift_engine #(.BITS(BYTE_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (!enable),
        .tick      (tick),
        .tx_byte   (tx_sel),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (req) nxt = ST_WAIT_GRANT;
            ST_WAIT_GRANT: if (!enable) nxt = ST_FINISH;
                           else if (bus_grant) nxt = ST_LEAD;
            ST_LEAD:       if (!enable) nxt = ST_FINISH;
                           else if (tick) nxt = ST_SHIFT;
            ST_SHIFT:      if (!enable) nxt = ST_FINISH;
                           else if (byte_done && (idx == last_idx)) nxt = ST_TRAIL;
            ST_TRAIL:      if (!enable) nxt = ST_FINISH;
                           else if (tick) nxt = ST_FINISH;
            ST_FINISH:     nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ack     = (state == ST_IDLE) && req;
        busy    = (state != ST_IDLE);
        done    = (state == ST_FINISH);
        run     = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL);
        cs_n    = !run;
        bus_req = run || (state == ST_WAIT_GRANT);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_STROBE;
            addr_q  <= '0;
            wdata_q <= '0;
            idx     <= '0;
            status  <= '0;
            rdata   <= '0;
            for (int i = 0; i < FRAME_MAX; i++) rx_q[i] <= '0;
        end else begin
            if (ack) begin
                op_q    <= op_e'(req_op);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if ((state == ST_LEAD) && tick) begin
                idx <= '0;
            end else if ((state == ST_SHIFT) && byte_done) begin
                rx_q[idx] <= rx_byte;
                idx       <= IDX_W'(idx + 1'b1);
            end
            if ((state != ST_IDLE) && (state != ST_FINISH) && (nxt == ST_FINISH)) begin
                if (!enable) begin
                    status <= '0;
                    rdata  <= '0;
                end else begin
                    status <= rx_q[0] & STATUS_KEEP;
                    rdata  <= (op_q == OP_READ) ? {rx_q[1], rx_q[2]} : '0;
                end
            end
        end
    end

    p_busy_after_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> busy);
    p_cs_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(bus_grant));
    p_bus_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> bus_req);
    p_status_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status[BYTE_W-1] == 1'b0) && (status[0] == 1'b0));
    p_sclk_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    p_abort_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !cs_n) |=> done && !sclk);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(status) || done);
endmodule

// File: tb/radio_reg_seq_test.sv
`timescale 1ns/1ps
module radio_reg_seq_test;
    localparam int CLK_DIV = 4;
    localparam realtime HALF_NS = 20.0 * CLK_DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack, busy, done, bus_req, sclk, mosi, cs_n;
    logic        bus_grant = 1'b1;
    logic        miso = 1'b0;
    logic [7:0]  status;
    logic [15:0] rdata;

    int total = 0;
    int bad = 0;

    logic [7:0] resp [3];
    logic [7:0] got  [4];
    logic [7:0] rsh;
    int         sbit, nrx, nrise;
    realtime    t_csf, t_csr, t_r1, t_r2, t_lf;
    logic [7:0] st_seen;
    logic [15:0] rd_seen;

    always #10 clk = ~clk;

    radio_reg_seq #(.CLK_DIV(CLK_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .req(req), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .busy(busy),
        .done(done), .status(status), .rdata(rdata), .bus_req(bus_req),
        .bus_grant(bus_grant), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // slave model: MISO set at cs fall and just after each SCLK rise
    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            sbit  = 0;
            nrx   = 0;
            nrise = 0;
            t_csf = $realtime;
            miso  = resp[0][7];
        end else begin
            if (nrise == 0) t_r1 = $realtime;
            if (nrise == 1) t_r2 = $realtime;
            nrise = nrise + 1;
            rsh   = {rsh[6:0], mosi};
            sbit  = sbit + 1;
            if ((sbit % 8) == 0 && nrx < 4) begin
                got[nrx] = rsh;
                nrx = nrx + 1;
            end
            if (sbit / 8 < 3) miso = resp[sbit / 8][7 - (sbit % 8)];
            else              miso = 1'b0;
        end
    end
    always @(negedge sclk) t_lf = $realtime;
    always @(posedge cs_n) t_csr = $realtime;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                st_seen = status;
                rd_seen = rdata;
                break;
            end
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [15:0] wd);
        @(negedge clk);
        req = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        #1;
        chk(ack == 1'b1, "R1 ack on idle request", ack, 1);
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R1 busy after accept", busy, 1);
    endtask

    task automatic t_reset;
        chk(cs_n == 1'b1, "R6 reset cs_n high", cs_n, 1);
        chk(sclk == 1'b0, "R7 reset sclk low", sclk, 0);
        chk({busy, done, bus_req} == 3'b000, "R1 reset idle flags", {busy, done, bus_req}, 0);
        chk({status, rdata} == 24'h0, "R9 reset results", {status, rdata}, 0);
    endtask

    task automatic t_strobe(input logic [1:0] op);
        bit seen;
        resp[0] = 8'hFF; resp[1] = 8'h00; resp[2] = 8'h00;
        issue(op, 6'h13, 16'h0);
        wait_done(seen);
        chk(seen, "R3 strobe done", seen, 1);
        chk(nrx == 1, "R3 strobe byte count", nrx, 1);
        chk(got[0] == 8'h13, "R3 strobe byte", got[0], 8'h13);
        chk(st_seen == 8'h7E, "R3 status mask", st_seen, 8'h7E);
        chk(rd_seen == 16'h0, "R3 rdata zero", rd_seen, 0);
    endtask

    task automatic t_write;
        bit seen;
        resp[0] = 8'h81; resp[1] = 8'hAA; resp[2] = 8'h55;
        issue(2'b01, 6'h2A, 16'hBEEF);
        wait_done(seen);
        chk(seen, "R4 write done", seen, 1);
        chk(nrx == 3, "R4 write byte count", nrx, 3);
        chk({got[0], got[1], got[2]} == 24'h2ABEEF, "R4 write bytes",
            {got[0], got[1], got[2]}, 24'h2ABEEF);
        chk(st_seen == 8'h00, "R4 status from first byte", st_seen, 0);
        chk(t_r1 - t_csf >= HALF_NS, "R6 lead time", int'(t_r1 - t_csf), int'(HALF_NS));
        chk(t_csr - t_lf >= HALF_NS, "R6 trail time", int'(t_csr - t_lf), int'(HALF_NS));
        chk(t_r2 - t_r1 == 2.0 * HALF_NS, "R7 sclk period", int'(t_r2 - t_r1), int'(2.0 * HALF_NS));
        chk(nrise == 24, "R6 clocks in one frame", nrise, 24);
    endtask

    task automatic t_read;
        bit seen;
        resp[0] = 8'h5B; resp[1] = 8'h12; resp[2] = 8'h34;
        issue(2'b10, 6'h05, 16'hFFFF);
        wait_done(seen);
        chk(seen, "R5 read done", seen, 1);
        chk({got[0], got[1], got[2]} == 24'h450000, "R5 read bytes",
            {got[0], got[1], got[2]}, 24'h450000);
        chk(rd_seen == 16'h1234, "R5 read data", rd_seen, 16'h1234);
        chk(st_seen == 8'h5A, "R5 read status", st_seen, 8'h5A);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", done, 0);
        repeat (5) @(negedge clk);
        chk(rdata == 16'h1234, "R9 result held", rdata, 16'h1234);
    endtask

    task automatic t_grant;
        bit seen;
        resp[0] = 8'h04; resp[1] = 8'h00; resp[2] = 8'h00;
        bus_grant = 1'b0;
        issue(2'b00, 6'h07, 16'h0);
        repeat (30) @(negedge clk);
        chk(cs_n == 1'b1, "R2 cs_n waits for grant", cs_n, 1);
        chk(bus_req && busy, "R2 bus_req while waiting", {bus_req, busy}, 2'b11);
        bus_grant = 1'b1;
        wait_done(seen);
        chk(seen && st_seen == 8'h04, "R2 completes after grant", st_seen, 8'h04);
        @(negedge clk);
        chk(bus_req == 1'b0, "R2 bus released", bus_req, 0);
    endtask

    task automatic t_busy_ignore;
        bit seen;
        resp[0] = 8'h02; resp[1] = 8'h00; resp[2] = 8'h00;
        issue(2'b01, 6'h11, 16'hA5C3);
        repeat (20) @(negedge clk);
        req = 1'b1; req_op = 2'b10; req_addr = 6'h3F;
        #1;
        chk(ack == 1'b0, "R1 no ack while busy", ack, 0);
        @(negedge clk);
        req = 1'b0;
        wait_done(seen);
        chk({got[0], got[1], got[2]} == 24'h11A5C3, "R1 frame unchanged",
            {got[0], got[1], got[2]}, 24'h11A5C3);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R1 late request dropped", {busy, cs_n}, 2'b01);
    endtask

    task automatic t_abort_grant;
        bit seen;
        bus_grant = 1'b0;
        issue(2'b00, 6'h01, 16'h0);
        repeat (4) @(negedge clk);
        enable = 1'b0;
        wait_done(seen);
        chk(seen, "R8 abort waiting grant done", seen, 1);
        chk({st_seen, rd_seen} == 24'h0, "R8 zero result no grant", {st_seen, rd_seen}, 0);
        chk(cs_n == 1'b1, "R8 never selected", cs_n, 1);
        @(negedge clk);
        enable = 1'b1;
        bus_grant = 1'b1;
        chk(bus_req == 1'b0, "R8 bus released", bus_req, 0);
    endtask

    task automatic t_abort_mid;
        bit seen;
        resp[0] = 8'h7E; resp[1] = 8'hCD; resp[2] = 8'hEF;
        issue(2'b10, 6'h22, 16'h0);
        for (int i = 0; i < 500 && nrise < 4; i++) @(negedge clk);
        enable = 1'b0;
        wait_done(seen);
        chk(seen, "R8 abort mid frame done", seen, 1);
        chk({st_seen, rd_seen} == 24'h0, "R8 zero result mid frame", {st_seen, rd_seen}, 0);
        chk(cs_n == 1'b1 && sclk == 1'b0 && bus_req == 1'b0, "R8 lines idle",
            {cs_n, sclk, bus_req}, 3'b100);
        @(negedge clk);
        enable = 1'b1;
    endtask

    initial begin
        #(20.0 * 150000);
        bad++;
        total++;
        $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        resp[0] = '0; resp[1] = '0; resp[2] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_strobe(2'b00);
        t_strobe(2'b11);
        t_write();
        t_read();
        t_grant();
        t_busy_ignore();
        t_abort_grant();
        t_read();
        t_abort_mid();
        t_write();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule